// File: doc/BRIEF.md
# Drive Select and Head Address Latch

This block is the host-facing selection logic of one drive that shares a multi-drive interface with other drives. The host drives a unit number, and the block asserts its select output only when that number matches the drive's unit-number switch. The host also presents head and platter addressing and a pair of diagnostic track-offset lines. While the drive is selected and ready, these lines are captured into a holding register on a rising edge of a host strobe. The held copy then feeds the read/write and servo logic.

The block also forms the drive's status lines toward the host. Ready and ready-to-seek are gated by selection. The busy-seeking line is placed on a bit position given by the unit number, so that several drives can share one field without collision. Four sticky attention conditions report that the drive became ready, that a seek completed, that a seek failed to complete, and that an illegal track address was accepted. These flags clear when the host moves selection away from the drive. An interrupt option input removes the selection gating from the host status lines, so an unselected drive can still report.

Top module: `drive_select_latch`

## Requirements
- R1: `sel_o` is high exactly when `host_unit` equals `unit_sw`; this output is combinational.
- R2: At a clock edge where `addr_strobe` is high, was low at the previous edge, `sel_o` is high and `drive_ready` is high, the five address lines are captured. After that edge, `held_*` show them. The bench packs the five lines into a 5-bit value in this order: bit0 head, bit1 platter, bit2 extension, bit3 offset-plus, bit4 offset-minus.
- R3: At every clock edge where `drive_ready` is low, all five held outputs clear to 0.
- R4: At any other edge the held outputs keep their value. This covers a strobe that stays high, a strobe edge while the drive is not selected, and changes on the address lines.
- R5: `host_ready_o` = `drive_ready` AND (`sel_o` OR `intr_opt`).
- R6: `busy_seek_o` has only bit number `unit_sw` able to be high, and that bit equals `pos_busy` AND `drive_ready`. Selection does not gate it.
- R7: There are four attention flags, bit0 became-ready, bit1 seek-complete, bit2 seek-incomplete and bit3 illegal-address. Each flag sets one clock after its event and stays set. The became-ready event is `drive_ready` rising between edges. The other three events are `seek_done`, `seek_fail` and `illegal_addr` high at an edge.
- R8: At an edge where `sel_o` was high at the previous edge and is now low, every flag clears, except a flag whose event occurs at that same edge, which sets.
- R9: `attn_o`, `seek_inc_o` (the seek-incomplete flag) and `seek_rdy_o` (`drive_ready` AND NOT `pos_busy`) are gated by (`sel_o` OR `intr_opt`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_sw | input | 2 | Unit-number switch setting |
| host_unit | input | 2 | Unit number driven by the host |
| intr_opt | input | 1 | Interrupt option: remove selection gating from status |
| drive_ready | input | 1 | Drive ready condition from the start/stop control |
| pos_busy | input | 1 | Positioner busy |
| seek_done | input | 1 | Seek completed event |
| seek_fail | input | 1 | Seek failed to complete event |
| illegal_addr | input | 1 | Illegal track address accepted event |
| addr_strobe | input | 1 | Host strobe for the address lines |
| head_sel | input | 1 | Head select line |
| plat_sel | input | 1 | Platter select line |
| plat_ext | input | 1 | Platter select extension line |
| ofs_plus | input | 1 | Track offset plus line |
| ofs_minus | input | 1 | Track offset minus line |
| sel_o | output | 1 | Drive selected |
| held_head | output | 1 | Held head select |
| held_plat | output | 1 | Held platter select |
| held_ext | output | 1 | Held platter extension |
| held_ofs_plus | output | 1 | Held offset plus |
| held_ofs_minus | output | 1 | Held offset minus |
| host_ready_o | output | 1 | Ready status to host |
| seek_rdy_o | output | 1 | Ready to seek/read/write status |
| seek_inc_o | output | 1 | Seek incomplete status |
| busy_seek_o | output | 4 | Busy-seeking field, one bit per unit |
| attn_o | output | 4 | Attention flags as seen by the host |

## Verification
The hardest case to reach is a deselect edge that lands on the same edge as a fresh attention event. There, clearing and setting compete, and the result shows only when the interrupt option makes the flags visible while the drive is unselected. The bench first sets a flag and then enables the option. In one step it moves `host_unit` away and pulses a different event, and it then checks that only the new flag survives. A second case that is hard to reach is a strobe that stays high. The bench holds the strobe high across changing address lines to show that a level does not reload the register.

// File: rtl/dsl_pkg.sv
// Shared types for the drive select and head address latch.
// Assumes the attention flag order is fixed by the host status field.
package dsl_pkg;
    localparam int ATTN_N = 4;

    typedef enum logic [1:0] {
        ATTN_BECAME_RDY = 2'd0,
        ATTN_SEEK_DONE  = 2'd1,
        ATTN_SEEK_FAIL  = 2'd2,
        ATTN_ILLEGAL    = 2'd3
    } attn_idx_e;

    typedef struct packed {
        logic ofs_minus;
        logic ofs_plus;
        logic plat_ext;
        logic plat_sel;
        logic head_sel;
    } hd_addr_t;
endpackage

// File: rtl/dsl_unit_match.sv
// Unit match and busy placement: compares the host unit number to the switch
// and places busy on the bit of this drive's unit. Purely combinational;
// assumes both unit inputs are already synchronous to clk.
module dsl_unit_match #(
    parameter int UNIT_W = 2,
    localparam int UNITS = 1 << UNIT_W
) (
    input  logic [UNIT_W-1:0] unit_sw,
    input  logic [UNIT_W-1:0] host_unit,
    input  logic              pos_busy,
    input  logic              drive_ready,
    output logic              sel,
    output logic [UNITS-1:0]  busy_field
);
    // Select decode: match of host number against switch.
    always_comb sel = (host_unit == unit_sw);

    // One busy bit per unit position; only this drive's position may be high.
    for (genvar u = 0; u < UNITS; u++) begin : g_busy
        always_comb busy_field[u] = (unit_sw == UNIT_W'(u)) && pos_busy && drive_ready;
    end
endmodule

// File: rtl/dsl_addr_hold.sv
// Holding register for head/platter/offset lines. Loads on a strobe rising
// edge while selected and ready, clears while not ready, else holds.
// Assumes the strobe is synchronous to clk and held for at least one cycle.
module dsl_addr_hold
    import dsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strobe,
    input  logic     sel,
    input  logic     drive_ready,
    input  hd_addr_t addr_in,
    output hd_addr_t addr_held
);
    logic strobe_q;
    logic load;

    // Remember the strobe level of the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Load request: strobe edge while the drive is selected and ready.
    always_comb load = strobe && !strobe_q && sel && drive_ready;

    // Holding register update: clear when not ready, load on request.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive_ready) addr_held <= '0;
        else if (load)              addr_held <= addr_in;
    end
endmodule

// File: rtl/dsl_attn_track.sv
// Sticky attention flags. Each flag sets on its event and clears at a
// deselect edge; a coincident event wins over the clear. Assumes event
// inputs are single-cycle or level signals synchronous to clk.
module dsl_attn_track
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              drive_ready,
    input  logic              seek_done,
    input  logic              seek_fail,
    input  logic              illegal_addr,
    output logic [ATTN_N-1:0] flags
);
    logic              rdy_q;
    logic              sel_q;
    logic              deselect;
    logic [ATTN_N-1:0] events;

    // Previous-edge copies of ready and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            rdy_q <= drive_ready;
            sel_q <= sel;
        end
    end

    // Event vector in the fixed flag order and the deselect edge.
    always_comb begin
        events                  = '0;
        events[ATTN_BECAME_RDY] = drive_ready && !rdy_q;
        events[ATTN_SEEK_DONE]  = seek_done;
        events[ATTN_SEEK_FAIL]  = seek_fail;
        events[ATTN_ILLEGAL]    = illegal_addr;
        deselect                = sel_q && !sel;
    end

    // One sticky flag per condition.
    for (genvar i = 0; i < ATTN_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= events[i] || (flags[i] && !deselect);
        end
    end
endmodule

// File: rtl/drive_select_latch.sv
// Drive select and head address latch: unit select, address holding register,
// host status gating with interrupt option, busy placement and attention.
// Assumes all inputs are synchronous to clk; line drivers live elsewhere.
module drive_select_latch
    import dsl_pkg::*;
#(
    parameter int UNIT_W = 2,
    localparam int UNITS = 1 << UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] unit_sw,
    input  logic [UNIT_W-1:0] host_unit,
    input  logic              intr_opt,
    input  logic              drive_ready,
    input  logic              pos_busy,
    input  logic              seek_done,
    input  logic              seek_fail,
    input  logic              illegal_addr,
    input  logic              addr_strobe,
    input  logic              head_sel,
    input  logic              plat_sel,
    input  logic              plat_ext,
    input  logic              ofs_plus,
    input  logic              ofs_minus,
    output logic              sel_o,
    output logic              held_head,
    output logic              held_plat,
    output logic              held_ext,
    output logic              held_ofs_plus,
    output logic              held_ofs_minus,
    output logic              host_ready_o,
    output logic              seek_rdy_o,
    output logic              seek_inc_o,
    output logic [UNITS-1:0]  busy_seek_o,
    output logic [ATTN_N-1:0] attn_o
);
    logic              sel;
    logic              visible;
    hd_addr_t          addr_in;
    hd_addr_t          addr_held;
    logic [ATTN_N-1:0] attn_flags;

    dsl_unit_match #(.UNIT_W(UNIT_W)) u_match (
        .unit_sw     (unit_sw),
        .host_unit   (host_unit),
        .pos_busy    (pos_busy),
        .drive_ready (drive_ready),
        .sel         (sel),
        .busy_field  (busy_seek_o)
    );

    // Gather the five address lines into the holding-register type.
    always_comb begin
        addr_in.head_sel  = head_sel;
        addr_in.plat_sel  = plat_sel;
        addr_in.plat_ext  = plat_ext;
        addr_in.ofs_plus  = ofs_plus;
        addr_in.ofs_minus = ofs_minus;
    end

    dsl_addr_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (addr_strobe),
        .sel         (sel),
        .drive_ready (drive_ready),
        .addr_in     (addr_in),
        .addr_held   (addr_held)
    );

    dsl_attn_track u_attn (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .drive_ready  (drive_ready),
        .seek_done    (seek_done),
        .seek_fail    (seek_fail),
        .illegal_addr (illegal_addr),
        .flags        (attn_flags)
    );

    // Host status: selection gating, bypassed by the interrupt option.
    always_comb begin
        visible        = sel || intr_opt;
        sel_o          = sel;
        host_ready_o   = drive_ready && visible;
        seek_rdy_o     = drive_ready && !pos_busy && visible;
        seek_inc_o     = attn_flags[ATTN_SEEK_FAIL] && visible;
        attn_o         = attn_flags & {ATTN_N{visible}};
        held_head      = addr_held.head_sel;
        held_plat      = addr_held.plat_sel;
        held_ext       = addr_held.plat_ext;
        held_ofs_plus  = addr_held.ofs_plus;
        held_ofs_minus = addr_held.ofs_minus;
    end
endmodule

// File: rtl/dsl_chk.sv
// Property checker for drive_select_latch, attached by bind.
module dsl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       drive_ready,
    input logic       addr_strobe,
    input logic       pos_busy,
    input logic       seek_done,
    input logic       seek_fail,
    input logic       illegal_addr,
    input logic       host_ready_o,
    input logic [4:0] held,
    input logic [3:0] busy_seek_o,
    input logic [3:0] flags
);
    // R3
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_ready |=> (held == 5'd0));
    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_ready && !addr_strobe) |=> $stable(held));
    // R5
    ready_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready_o |-> drive_ready);
    // R6
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_seek_o));
    // R6
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_seek_o != 4'd0) |-> (pos_busy && drive_ready));
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done |=> flags[1]);
    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_fail |=> flags[2]);
    // R7
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_addr |=> flags[3]);
endmodule

bind drive_select_latch dsl_chk u_dsl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_ready  (drive_ready),
    .addr_strobe  (addr_strobe),
    .pos_busy     (pos_busy),
    .seek_done    (seek_done),
    .seek_fail    (seek_fail),
    .illegal_addr (illegal_addr),
    .host_ready_o (host_ready_o),
    .held         ({held_ofs_minus, held_ofs_plus, held_ext, held_plat, held_head}),
    .busy_seek_o  (busy_seek_o),
    .flags        (attn_flags)
);

// File: tb/drive_select_latch_bench.sv
module drive_select_latch_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] unit_sw = '0, host_unit = '0;
    logic intr_opt = 0, drive_ready = 0, pos_busy = 0;
    logic seek_done = 0, seek_fail = 0, illegal_addr = 0, addr_strobe = 0;
    logic [4:0] addr = '0;
    logic sel_o, held_head, held_plat, held_ext, held_ofs_plus, held_ofs_minus;
    logic host_ready_o, seek_rdy_o, seek_inc_o;
    logic [3:0] busy_seek_o, attn_o;
    logic [4:0] held;
    int checks = 0, errors = 0;
    logic done = 0;

    always #5 clk = ~clk;

    drive_select_latch u_drive_select_latch (
        .clk(clk), .rst_n(rst_n), .unit_sw(unit_sw), .host_unit(host_unit),
        .intr_opt(intr_opt), .drive_ready(drive_ready), .pos_busy(pos_busy),
        .seek_done(seek_done), .seek_fail(seek_fail), .illegal_addr(illegal_addr),
        .addr_strobe(addr_strobe), .head_sel(addr[0]), .plat_sel(addr[1]),
        .plat_ext(addr[2]), .ofs_plus(addr[3]), .ofs_minus(addr[4]),
        .sel_o(sel_o), .held_head(held_head), .held_plat(held_plat),
        .held_ext(held_ext), .held_ofs_plus(held_ofs_plus),
        .held_ofs_minus(held_ofs_minus), .host_ready_o(host_ready_o),
        .seek_rdy_o(seek_rdy_o), .seek_inc_o(seek_inc_o),
        .busy_seek_o(busy_seek_o), .attn_o(attn_o)
    );

    assign held = {held_ofs_minus, held_ofs_plus, held_ext, held_plat, held_head};

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst_n = 1;
        tick;
        // Reset state (R3, R7)
        intr_opt = 1;
        #1;
        chk("R3 reset held", held, 0);
        chk("R7 reset attn", attn_o, 0);
        intr_opt = 0;

        // R1 and R6 exhaustive sweep over switch, host number, busy and ready
        for (int u = 0; u < 4; u++) begin
            for (int h = 0; h < 4; h++) begin
                unit_sw = 2'(u); host_unit = 2'(h);
                #1;
                chk("R1 select", sel_o, (u == h));
            end
            for (int b = 0; b < 4; b++) begin
                host_unit = 2'(u + 1); pos_busy = b[0]; drive_ready = b[1];
                #1;
                chk("R6 busy field", busy_seek_o, (b == 3) ? (32'd1 << u) : 0);
            end
        end
        drive_ready = 0; pos_busy = 0;
        tick;

        // R5 and R9 sweep over select, option, ready and busy
        unit_sw = 2'd3;
        for (int k = 0; k < 16; k++) begin
            host_unit = k[0] ? 2'd3 : 2'd0;
            intr_opt = k[1]; drive_ready = k[2]; pos_busy = k[3];
            #1;
            chk("R5 ready status", host_ready_o, k[2] && (k[0] || k[1]));
            chk("R9 seek ready", seek_rdy_o, k[2] && !k[3] && (k[0] || k[1]));
        end
        drive_ready = 0; pos_busy = 0; intr_opt = 0;
        host_unit = 2'd0;
        tick; tick;

        // Attention flags (R7, R8, R9)
        unit_sw = 2'd2; host_unit = 2'd2;
        tick;
        drive_ready = 1; tick;
        chk("R7 became ready", attn_o, 4'b0001);
        seek_done = 1; tick; seek_done = 0; tick;
        chk("R7 seek done", attn_o, 4'b0011);
        seek_fail = 1; tick; seek_fail = 0;
        chk("R7 seek fail", attn_o, 4'b0111);
        chk("R9 seek incomplete", seek_inc_o, 1);
        illegal_addr = 1; tick; illegal_addr = 0;
        chk("R7 illegal", attn_o, 4'b1111);
        host_unit = 2'd1; #1;
        chk("R9 gated unselected", attn_o, 0);
        tick; intr_opt = 1; #1;
        chk("R8 cleared on deselect", attn_o, 0);
        seek_fail = 1; tick; seek_fail = 0;
        chk("R9 option unselected attn", attn_o, 4'b0100);
        chk("R9 option seek incomplete", seek_inc_o, 1);
        intr_opt = 0; #1;
        chk("R9 option off", attn_o, 0);
        host_unit = 2'd2; #1;
        chk("R9 reselected", attn_o, 4'b0100);
        tick;
        intr_opt = 1; host_unit = 2'd0; seek_done = 1; tick; seek_done = 0;
        chk("R8 event wins at deselect", attn_o, 4'b0010);
        intr_opt = 0;

        // Holding register sweep over all 32 address patterns (R2, R4)
        unit_sw = 2'd1; host_unit = 2'd1;
        for (int v = 0; v < 32; v++) begin
            addr = 5'(v); addr_strobe = 0; tick;
            addr_strobe = 1; tick;
            chk("R2 load", held, v);
            addr = ~5'(v); tick;
            chk("R4 strobe level", held, v);
        end
        // Strobe edge while unselected (R4)
        addr_strobe = 0; host_unit = 2'd0; tick;
        addr = 5'h0a; addr_strobe = 1; tick;
        chk("R4 unselected edge", held, 31);
        // Not ready clears and blocks load (R3)
        addr_strobe = 0; drive_ready = 0; tick;
        chk("R3 clear", held, 0);
        host_unit = 2'd1; addr_strobe = 1; tick;
        chk("R3 no load while not ready", held, 0);
        addr_strobe = 0; drive_ready = 1; tick;
        addr = 5'h15; addr_strobe = 1; tick;
        chk("R2 load after ready", held, 5'h15);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule